// File: doc/BRIEF.md
# Memory Access Region Predictor

This block guesses, before dispatch, whether a load or store will touch the stack or the rest of memory (global data or heap). Its answer steers the instruction to one of two separate memory pipelines. A lookup carries the instruction PC, a caller identifier taken from the link register, and a two-bit base-register hint from decode. When the base register already shows the region, the hint decides and the table is not consulted. A stack-pointer or frame-pointer base means stack. A global-pointer base means non-stack.

Every other lookup reads a one-bit entry from a direct-mapped table. The table index is the low PC bits XORed with a context word. That word is built from the low caller-ID bits and a global branch-history register. Each entry keeps only the last region seen at that index.

Once translation has resolved the true region, an update port hands back the index, the hint flag and the predicted bit that the lookup returned. The update rewrites the entry and raises a one-cycle mispredict pulse when the guess was wrong, so the access can be reissued to the other pipeline.

Top module: `region_predictor`

## Requirements
- R1: Reset is synchronous and active high. While reset is high and on the first cycle after it, `pred_valid` and `mispredict` are 0. Every table entry reads 0 (non-stack) after reset, including entries written before reset.
- R2: With the default parameters, the lookup index is `lk_pc[11:2] XOR {2'b00, lk_cid[3:0], ghr[3:0]}`. It is returned on `pred_idx`.
- R3: An entry holds a single bit: 1 = stack, 0 = non-stack. An unhinted update stores `upd_actual` as is, so one opposite outcome flips the next prediction for that index.
- R4: `lk_hint` = 2'b01 (stack or frame pointer base) gives `pred_stack`=1 and `pred_hinted`=1, whatever the table holds.
- R5: `lk_hint` = 2'b10 (global pointer base) gives `pred_stack`=0 and `pred_hinted`=1, whatever the table holds. Hint values 2'b00 and 2'b11 use the table and give `pred_hinted`=0.
- R6: An update with `upd_hinted`=1 leaves the table unchanged.
- R7: When `br_valid` is high, `br_taken` shifts into bit 0 of the 4-bit history and the older bits move up. A lookup in the same cycle uses the history as it was before the shift.
- R8: `mispredict` is high in the cycle after an accepted update exactly when `upd_pred` differs from `upd_actual`. It is 0 in any cycle that follows a cycle without an update.
- R9: When an unhinted update and a lookup address the same index in the same cycle, the prediction returns the value being written.
- R10: The prediction outputs are valid in the cycle after `lk_valid` is sampled high. `pred_valid` is 0 after a cycle without a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Instruction PC |
| lk_cid | input | 32 | Caller identifier (link register value) |
| lk_hint | input | 2 | Base-register hint: 00 none, 01 stack, 10 global, 11 none |
| br_valid | input | 1 | A branch outcome is presented |
| br_taken | input | 1 | Branch outcome bit |
| pred_valid | output | 1 | Prediction outputs are valid |
| pred_stack | output | 1 | 1 = stack, 0 = non-stack |
| pred_hinted | output | 1 | Prediction came from the decode hint |
| pred_idx | output | 10 | Table index used by the lookup |
| upd_valid | input | 1 | Resolved-region update |
| upd_idx | input | 10 | Index returned by the lookup |
| upd_hinted | input | 1 | The lookup was decided by a hint |
| upd_pred | input | 1 | Region that was predicted |
| upd_actual | input | 1 | Region resolved from the translation tag |
| mispredict | output | 1 | One-cycle pulse: the prediction was wrong |

## Verification
Every result is due exactly one clock edge after the cycle that presents its stimulus. The prediction follows the lookup edge, the mispredict pulse follows the update edge, and a table write or history shift shows up in a lookup sampled on any later edge. The bench drives each stimulus on a falling edge and checks outputs on the next falling edge. Before that edge it computes the expected values from its own table and history model, including the same-cycle forwarding and the old-history case. The model is advanced only after the check.

// File: rtl/rp_pkg.sv
package rp_pkg;
  typedef enum logic [1:0] {
    HINT_NONE   = 2'b00,
    HINT_STACK  = 2'b01,
    HINT_GLOBAL = 2'b10,
    HINT_RSVD   = 2'b11
  } hint_e;
endpackage

// File: rtl/rp_index.sv
module rp_index #(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int IDX_W    = 10,
  parameter int CID_BITS = 4,
  parameter int GHR_W    = 4
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  cid,
  input  logic [GHR_W-1:0] ghr,
  output logic [IDX_W-1:0] idx
);
  localparam int CTX_W = CID_BITS + GHR_W;

  logic [CTX_W-1:0] ctx;
  logic [IDX_W-1:0] ctx_fit;

  assign ctx = {cid[CID_BITS-1:0], ghr};

  generate
    if (CTX_W >= IDX_W) begin : g_trim
      assign ctx_fit = ctx[IDX_W-1:0];
    end else begin : g_pad
      assign ctx_fit = {{(IDX_W-CTX_W){1'b0}}, ctx};
    end
  endgenerate

  assign idx = pc[PC_LSB +: IDX_W] ^ ctx_fit;
endmodule

// File: rtl/rp_ghr.sv
module rp_ghr #(
  parameter int GHR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_valid,
  input  logic             br_taken,
  output logic [GHR_W-1:0] ghr
);
  always_ff @(posedge clk) begin
    if (rst) ghr <= '0;
    else if (br_valid) ghr <= (ghr << 1) | GHR_W'(br_taken);
  end

  AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (rst)
    br_valid |=> (ghr[0] == $past(br_taken))); // R7
  AST_GHR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> $stable(ghr)); // R7
endmodule

// File: rtl/rp_table.sv
module rp_table #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic mem [DEPTH];

  // Storage: cleared on reset, one write port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 1'b0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_bit;
    end
  end

  // Registered read with same-edge write forwarding
  always_ff @(posedge clk) begin
    if (rst) rd_bit <= 1'b0;
    else if (rd_en) rd_bit <= (wr_en && (wr_idx == rd_idx)) ? wr_bit : mem[rd_idx];
  end

  AST_FWD_SAME_IDX: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && (rd_idx == wr_idx)) |=> (rd_bit == $past(wr_bit))); // R9
endmodule

// File: rtl/region_predictor.sv
module region_predictor
  import rp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int IDX_W    = 10,
  parameter int CID_BITS = 4,
  parameter int GHR_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [PC_W-1:0]  lk_cid,
  input  logic [1:0]       lk_hint,
  input  logic             br_valid,
  input  logic             br_taken,
  output logic             pred_valid,
  output logic             pred_stack,
  output logic             pred_hinted,
  output logic [IDX_W-1:0] pred_idx,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_hinted,
  input  logic             upd_pred,
  input  logic             upd_actual,
  output logic             mispredict
);
  hint_e            hint_in;
  logic [GHR_W-1:0] ghr;
  logic [IDX_W-1:0] lk_idx;
  logic             hint_hit, hint_bit;
  logic             tbl_bit, tbl_wr;
  logic             hinted_q, hint_bit_q;

  assign hint_in  = hint_e'(lk_hint);
  assign hint_hit = (hint_in == HINT_STACK) || (hint_in == HINT_GLOBAL);
  assign hint_bit = (hint_in == HINT_STACK);
  assign tbl_wr   = upd_valid && !upd_hinted;

  rp_ghr #(.GHR_W(GHR_W)) u_ghr (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_taken(br_taken), .ghr(ghr)
  );

  rp_index #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .CID_BITS(CID_BITS), .GHR_W(GHR_W)
  ) u_index (
    .pc(lk_pc), .cid(lk_cid), .ghr(ghr), .idx(lk_idx)
  );

  rp_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .rd_en(lk_valid), .rd_idx(lk_idx), .rd_bit(tbl_bit),
    .wr_en(tbl_wr), .wr_idx(upd_idx), .wr_bit(upd_actual)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      hinted_q   <= 1'b0;
      hint_bit_q <= 1'b0;
      pred_idx   <= '0;
      mispredict <= 1'b0;
    end else begin
      pred_valid <= lk_valid;
      if (lk_valid) begin
        hinted_q   <= hint_hit;
        hint_bit_q <= hint_bit;
        pred_idx   <= lk_idx;
      end
      mispredict <= upd_valid && (upd_pred != upd_actual);
    end
  end

  assign pred_hinted = hinted_q;
  assign pred_stack  = hinted_q ? hint_bit_q : tbl_bit;

  AST_HINT_STACK: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && hint_in == HINT_STACK) |=> (pred_valid && pred_stack && pred_hinted)); // R4
  AST_HINT_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && hint_in == HINT_GLOBAL) |=> (pred_valid && !pred_stack && pred_hinted)); // R5
  AST_IDLE_NO_PRED: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid); // R10
  AST_MISPRED_MATCH: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (upd_pred == upd_actual)) |=> !mispredict); // R8
  AST_MISPRED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> !mispredict); // R8
endmodule

// File: tb/sim_region_predictor.sv
module sim_region_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0, lk_cid = '0;
  logic [1:0]  lk_hint = '0;
  logic        br_valid = 1'b0, br_taken = 1'b0;
  logic        pred_valid, pred_stack, pred_hinted, mispredict;
  logic [9:0]  pred_idx;
  logic        upd_valid = 1'b0, upd_hinted = 1'b0, upd_pred = 1'b0, upd_actual = 1'b0;
  logic [9:0]  upd_idx = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit       ref_tbl [1024];
  bit [3:0] ref_ghr;
  logic       g_s, g_h;
  logic [9:0] g_idx;

  always #10 clk = ~clk;

  region_predictor u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_cid(lk_cid),
    .lk_hint(lk_hint), .br_valid(br_valid), .br_taken(br_taken),
    .pred_valid(pred_valid), .pred_stack(pred_stack), .pred_hinted(pred_hinted),
    .pred_idx(pred_idx), .upd_valid(upd_valid), .upd_idx(upd_idx),
    .upd_hinted(upd_hinted), .upd_pred(upd_pred), .upd_actual(upd_actual),
    .mispredict(mispredict)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic [7:0]  cid;
    logic [1:0]  hint;
    logic        act;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 8'h00, 2'b00, 1'b1},
    '{32'h0000_1000, 8'h00, 2'b00, 1'b1},
    '{32'h0000_1000, 8'h00, 2'b00, 1'b0},
    '{32'h0000_2004, 8'h03, 2'b01, 1'b1},
    '{32'h0000_2004, 8'h03, 2'b10, 1'b1},
    '{32'h0000_3ffc, 8'h0f, 2'b11, 1'b1},
    '{32'h0000_3ffc, 8'h0f, 2'b11, 1'b1},
    '{32'h1234_5678, 8'ha5, 2'b00, 1'b0},
    '{32'h0000_0ffc, 8'hf0, 2'b00, 1'b1},
    '{32'h0000_0ffc, 8'h10, 2'b00, 1'b0},
    '{32'h0000_0ffc, 8'hf0, 2'b00, 1'b0},
    '{32'h8000_0040, 8'h01, 2'b10, 1'b0}
  };

  function automatic logic [9:0] ref_idx(logic [31:0] pc, logic [31:0] cid, bit [3:0] h);
    return pc[11:2] ^ {2'b00, cid[3:0], h};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 1024; i++) ref_tbl[i] = 1'b0;
    ref_ghr = '0;
  endtask

  // One cycle of stimulus with every output checked one edge later
  task automatic step(string req, bit lkv, logic [31:0] pc, logic [31:0] cid, logic [1:0] hint,
                      bit upv, logic [9:0] uidx, bit uh, bit upred, bit uact,
                      bit brv, bit brt);
    logic [9:0] e_idx;
    bit e_s, e_h, e_mp;
    e_idx = ref_idx(pc, cid, ref_ghr);
    if (hint == 2'b01) begin e_s = 1; e_h = 1; end
    else if (hint == 2'b10) begin e_s = 0; e_h = 1; end
    else begin
      e_h = 0;
      e_s = (upv && !uh && uidx == e_idx) ? uact : ref_tbl[e_idx];
    end
    e_mp = upv && (upred != uact);
    @(negedge clk);
    lk_valid = lkv; lk_pc = pc; lk_cid = cid; lk_hint = hint;
    upd_valid = upv; upd_idx = uidx; upd_hinted = uh; upd_pred = upred; upd_actual = uact;
    br_valid = brv; br_taken = brt;
    @(negedge clk);
    lk_valid = 0; upd_valid = 0; br_valid = 0;
    chk({req, " R10 pred_valid"}, 32'(pred_valid), 32'(lkv));
    chk({req, " R8 mispredict"}, 32'(mispredict), 32'(e_mp));
    if (lkv) begin
      chk({req, " R2 pred_idx"}, 32'(pred_idx), 32'(e_idx));
      chk({req, " R3 pred_stack"}, 32'(pred_stack), 32'(e_s));
      chk({req, " R5 pred_hinted"}, 32'(pred_hinted), 32'(e_h));
    end
    g_s = pred_stack; g_h = pred_hinted; g_idx = pred_idx;
    if (upv && !uh) ref_tbl[uidx] = uact;
    if (brv) ref_ghr = {ref_ghr[2:0], brt};
  endtask

  task automatic lookup(string req, logic [31:0] pc, logic [31:0] cid, logic [1:0] hint);
    step(req, 1, pc, cid, hint, 0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic update(string req, logic [9:0] idx, bit uh, bit upred, bit uact);
    step(req, 0, '0, '0, 2'b00, 1, idx, uh, upred, uact, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 pred_valid in reset", 32'(pred_valid), 0);
    chk("R1 mispredict in reset", 32'(mispredict), 0);
    rst = 0;
    model_reset();
    @(negedge clk);
    chk("R1 pred_valid after reset", 32'(pred_valid), 0);
    chk("R1 mispredict after reset", 32'(mispredict), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [9:0] ix;
    model_reset();
    do_reset();

    // Table of vectors: lookup, then resolve with the stored region
    for (int v = 0; v < NV; v++) begin
      lookup("R3 vec", VECS[v].pc, {24'h0, VECS[v].cid}, VECS[v].hint);
      update("R8 vec", g_idx, g_h, g_s, VECS[v].act);
    end

    // R1: unseen entry reads non-stack, and reset clears written entries
    lookup("R1 unseen", 32'h0000_0700, 32'h0, 2'b00);
    chk("R1 unseen non-stack", 32'(g_s), 0);
    ix = ref_idx(32'h0000_1000, 32'h0, ref_ghr);
    update("R3 set", ix, 0, 0, 1);
    do_reset();
    lookup("R1 cleared", 32'h0000_1000, 32'h0, 2'b00);
    chk("R1 entry cleared by reset", 32'(g_s), 0);

    // R3: one opposite outcome flips the entry
    ix = ref_idx(32'h0000_0040, 32'h0, ref_ghr);
    update("R3 write1", ix, 0, 0, 1);
    lookup("R3 read1", 32'h0000_0040, 32'h0, 2'b00);
    chk("R3 read stack", 32'(g_s), 1);
    update("R3 write0", ix, 0, 1, 0);
    lookup("R3 read0", 32'h0000_0040, 32'h0, 2'b00);
    chk("R3 flipped to non-stack", 32'(g_s), 0);

    // R4/R5: hints override a stack entry and a non-stack entry
    update("R4 prep", ix, 0, 0, 1);
    lookup("R5 global over stack", 32'h0000_0040, 32'h0, 2'b10);
    chk("R5 global hint", 32'(g_s), 0);
    update("R4 prep0", ix, 0, 1, 0);
    lookup("R4 stack over zero", 32'h0000_0040, 32'h0, 2'b01);
    chk("R4 stack hint", 32'(g_s), 1);
    lookup("R5 reserved uses table", 32'h0000_0040, 32'h0, 2'b11);
    chk("R5 reserved unhinted", 32'(g_h), 0);

    // R6: hinted update leaves the entry untouched
    update("R6 hinted write", ix, 1, 0, 1);
    lookup("R6 readback", 32'h0000_0040, 32'h0, 2'b00);
    chk("R6 entry unchanged", 32'(g_s), 0);

    // R7: history shift; same-cycle lookup sees the old history
    step("R7 shift1", 1, 32'h0000_0100, 32'h5, 2'b00, 0, '0, 0, 0, 0, 1, 1);
    chk("R7 old history idx", 32'(g_idx), 32'(10'h040 ^ 10'h050));
    lookup("R7 new history", 32'h0000_0100, 32'h5, 2'b00);
    chk("R7 new history idx", 32'(g_idx), 32'(10'h040 ^ 10'h051));

    // R9: forwarding of a same-cycle update to the same index
    ix = ref_idx(32'h0000_0200, 32'h2, ref_ghr);
    step("R9 fwd1", 1, 32'h0000_0200, 32'h2, 2'b00, 1, ix, 0, 0, 1, 0, 0);
    chk("R9 forwarded stack", 32'(g_s), 1);
    step("R9 fwd0", 1, 32'h0000_0200, 32'h2, 2'b00, 1, ix, 0, 1, 0, 0, 0);
    chk("R9 forwarded non-stack", 32'(g_s), 0);

    // R10/R8: idle cycle
    step("R10 idle", 0, '0, '0, 2'b00, 0, '0, 0, 0, 0, 0, 0);

    // Random streams against the model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] rpc, rcid;
      bit uv;
      rpc  = $urandom & 32'h0000_00fc;
      rcid = $urandom;
      uv   = ($urandom % 2) == 1;
      step("R3 random", ($urandom % 4) != 0, rpc, rcid, 2'($urandom),
           uv, 10'($urandom) & 10'h03f, ($urandom % 5) == 0, 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule